// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block drives the SCL clock of an I2C master. It keeps a high and a low count for each of three speed classes (standard, fast, high speed). A speed selector picks the count pair and the spike-suppression length to use. When the master drives SCL low, the block counts the low phase. It then releases the line and waits for the line to read high. The high count starts only once an input filter has accepted that high level, so a slow or stretching target lengthens the high phase instead of being overrun.

Every high phase gives one bit-sample strobe once the spike window has passed. Every low phase gives one SDA-change strobe a programmable number of cycles after SCL falls. The data path that shifts bytes uses these two strobes. The timing inputs are captured when the block is enabled and are ignored until it is disabled again. A status output reports the enable state. Disabling the block releases SCL and clears every counter at the next clock edge.

Top module: `scl_clock_gen`

## Requirements
- R1: Each SCL low phase (scl_low_o = 1) lasts exactly LCNT + 1 clock cycles.
- R2: When the SCL line follows the block's drive with no stretching, each released phase lasts HCNT + SPK + 3 clock cycles.
- R3: speed_i selects the count pair: 0 standard pair, 1 fast pair, 2 fast pair (fast-plus), 3 high-speed pair.
- R4: SPK is hs_spk_i when the resolved mode is high speed, and fs_spk_i in every other mode.
- R5: speed_i = 3 with hs_capable_i = 0 behaves exactly as speed_i = 1 (fast pair, fs_spk_i).
- R6: If SCL is held low externally for S cycles after release, the released phase lasts S + HCNT + SPK + 3 cycles, because the high counter waits for a filtered high level.
- R7: An excursion of the SCL input that lasts SPK samples or fewer is ignored. It takes SPK + 1 equal samples to change the filtered level. Correct filtering needs LCNT >= SPK.
- R8: sample_o pulses once per released phase, in released cycle SPK + 2 (counting from 0), plus any stretch cycles.
- R9: sda_change_o pulses once per low phase, in low cycle HOLD (counting from 0, HOLD <= LCNT).
- R10: Timing inputs are captured in the cycle enable_i rises. Changes to them while the block is enabled have no effect.
- R11: After reset, and one cycle after enable_i falls, SCL is released, both strobes are low and enabled_o is 0. enabled_o follows enable_i with one cycle of delay. Every enable begins with a full low phase (scl_low_o = 1 one cycle after enable_i rises).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run the clock generator |
| speed_i | input | 2 | Requested speed class |
| hs_capable_i | input | 1 | High-speed mode is available |
| ss_hcnt_i | input | CNT_W | Standard high count |
| ss_lcnt_i | input | CNT_W | Standard low count |
| fs_hcnt_i | input | CNT_W | Fast high count |
| fs_lcnt_i | input | CNT_W | Fast low count |
| hs_hcnt_i | input | CNT_W | High-speed high count |
| hs_lcnt_i | input | CNT_W | High-speed low count |
| fs_spk_i | input | SPK_W | Spike length, non-high-speed modes |
| hs_spk_i | input | SPK_W | Spike length, high-speed mode |
| sda_hold_i | input | HLD_W | SDA hold in cycles after SCL falls |
| scl_i | input | 1 | Sampled SCL line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sample_o | output | 1 | Bit-sample strobe |
| sda_change_o | output | 1 | SDA may change now |
| enabled_o | output | 1 | Enable status |

## Verification
On every cycle, the assertions check four things. The phase counters stay inside the captured low and high counts. The captured timing holds steady while the block is enabled. The filtered level only moves while the input disagrees with it. Disable releases SCL and silences both strobes one cycle later.

Only the bench scenarios can show the exact phase lengths, the strobe positions, the mode and fallback selection, the stretch and glitch behaviour, and that register changes made while enabled are ignored. The bench does this by measuring the waveform against a modelled open-drain line.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_FASTP = 2'd2,
    SPD_HIGH  = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel
  import scl_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8,
  parameter int HLD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       speed_i,
  input  logic             hs_capable_i,
  input  logic [CNT_W-1:0] ss_hcnt_i,
  input  logic [CNT_W-1:0] ss_lcnt_i,
  input  logic [CNT_W-1:0] fs_hcnt_i,
  input  logic [CNT_W-1:0] fs_lcnt_i,
  input  logic [CNT_W-1:0] hs_hcnt_i,
  input  logic [CNT_W-1:0] hs_lcnt_i,
  input  logic [SPK_W-1:0] fs_spk_i,
  input  logic [SPK_W-1:0] hs_spk_i,
  input  logic [HLD_W-1:0] sda_hold_i,
  output logic             en_o,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] lcnt_o,
  output logic [SPK_W-1:0] spk_o,
  output logic [HLD_W-1:0] hold_o
);
  speed_e           mode_eff;
  logic [CNT_W-1:0] hcnt_sel, lcnt_sel;
  logic [SPK_W-1:0] spk_sel;

  // high speed falls back to fast when the instance lacks it
  always_comb begin
    mode_eff = speed_e'(speed_i);
    if (mode_eff == SPD_HIGH && !hs_capable_i) mode_eff = SPD_FAST;
    case (mode_eff)
      SPD_STD:  begin hcnt_sel = ss_hcnt_i; lcnt_sel = ss_lcnt_i; end
      SPD_HIGH: begin hcnt_sel = hs_hcnt_i; lcnt_sel = hs_lcnt_i; end
      default:  begin hcnt_sel = fs_hcnt_i; lcnt_sel = fs_lcnt_i; end
    endcase
    spk_sel = (mode_eff == SPD_HIGH) ? hs_spk_i : fs_spk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      hcnt_o <= '0;
      lcnt_o <= '0;
      spk_o  <= '0;
      hold_o <= '0;
    end else begin
      en_o <= enable_i;
      if (enable_i && !en_o) begin
        hcnt_o <= hcnt_sel;
        lcnt_o <= lcnt_sel;
        spk_o  <= spk_sel;
        hold_o <= sda_hold_i;
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && enable_i) |=> ($stable(hcnt_o) && $stable(lcnt_o) && $stable(spk_o) && $stable(hold_o))); // R10
endmodule

// File: rtl/scl_glitch_filter.sv
module scl_glitch_filter #(
  parameter int SPK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [SPK_W-1:0] spk_i,
  input  logic             scl_i,
  output logic             filt_o
);
  logic [SPK_W-1:0] run_q;

  // a new level is accepted after spk_i+1 consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= 1'b1;
      run_q  <= '0;
    end else if (!enable_i) begin
      filt_o <= 1'b1;
      run_q  <= '0;
    end else if (scl_i == filt_o) begin
      run_q <= '0;
    end else if (run_q == spk_i) begin
      filt_o <= scl_i;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_FILT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && scl_i == filt_o) |=> $stable(filt_o)); // R7
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] hcnt_i,
  input  logic [CNT_W-1:0] lcnt_i,
  input  logic             filt_i,
  output logic             scl_low_o,
  output logic             sample_o,
  output logic             low_start_o
);
  phase_e           state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!enable_i) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_q <= PH_LOW;
          cnt_q   <= '0;
        end
        PH_LOW: begin
          if (cnt_q == lcnt_i) begin
            state_q <= PH_WAIT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_WAIT: begin
          // high count waits for the filtered line: clock stretching
          if (filt_i) begin
            state_q <= PH_HIGH;
            cnt_q   <= '0;
          end
        end
        PH_HIGH: begin
          if (cnt_q == hcnt_i) begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_low_o   = (state_q == PH_LOW);
  assign sample_o    = (state_q == PH_HIGH) && (cnt_q == '0);
  assign low_start_o = (state_q == PH_LOW) && (cnt_q == '0);

  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LOW) |-> (cnt_q <= lcnt_i)); // R1
  AST_HIGH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH) |-> (cnt_q <= hcnt_i)); // R2
  AST_SAMPLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R8
endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer #(
  parameter int HLD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic [HLD_W-1:0] hold_i,
  output logic             strobe_o
);
  logic             run_q;
  logic [HLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!enable_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= (hold_i != '0);
      cnt_q <= HLD_W'(1);
    end else if (run_q) begin
      if (cnt_q == hold_i) run_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign strobe_o = (start_i && hold_i == '0) || (run_q && cnt_q == hold_i);

  AST_SDA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R9
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8,
  parameter int HLD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       speed_i,
  input  logic             hs_capable_i,
  input  logic [CNT_W-1:0] ss_hcnt_i,
  input  logic [CNT_W-1:0] ss_lcnt_i,
  input  logic [CNT_W-1:0] fs_hcnt_i,
  input  logic [CNT_W-1:0] fs_lcnt_i,
  input  logic [CNT_W-1:0] hs_hcnt_i,
  input  logic [CNT_W-1:0] hs_lcnt_i,
  input  logic [SPK_W-1:0] fs_spk_i,
  input  logic [SPK_W-1:0] hs_spk_i,
  input  logic [HLD_W-1:0] sda_hold_i,
  input  logic             scl_i,
  output logic             scl_low_o,
  output logic             sample_o,
  output logic             sda_change_o,
  output logic             enabled_o
);
  logic [CNT_W-1:0] hcnt, lcnt;
  logic [SPK_W-1:0] spk;
  logic [HLD_W-1:0] hold;
  logic             filt, low_start;

  scl_cfg_sel #(.CNT_W(CNT_W), .SPK_W(SPK_W), .HLD_W(HLD_W)) u_cfg (
    .clk_i, .rst_ni, .enable_i, .speed_i, .hs_capable_i,
    .ss_hcnt_i, .ss_lcnt_i, .fs_hcnt_i, .fs_lcnt_i, .hs_hcnt_i, .hs_lcnt_i,
    .fs_spk_i, .hs_spk_i, .sda_hold_i,
    .en_o(enabled_o), .hcnt_o(hcnt), .lcnt_o(lcnt), .spk_o(spk), .hold_o(hold)
  );

  scl_glitch_filter #(.SPK_W(SPK_W)) u_filt (
    .clk_i, .rst_ni, .enable_i, .spk_i(spk), .scl_i, .filt_o(filt)
  );

  scl_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .enable_i, .hcnt_i(hcnt), .lcnt_i(lcnt), .filt_i(filt),
    .scl_low_o, .sample_o, .low_start_o(low_start)
  );

  sda_hold_timer #(.HLD_W(HLD_W)) u_hold (
    .clk_i, .rst_ni, .enable_i, .start_i(low_start), .hold_i(hold),
    .strobe_o(sda_change_o)
  );

  AST_DISABLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!scl_low_o && !sample_o && !sda_change_o && !enabled_o)); // R11
endmodule

// File: tb/tb_scl_clock_gen.sv
module tb_scl_clock_gen;
  localparam int CNT_W = 16;
  localparam int SPK_W = 8;
  localparam int HLD_W = 16;
  localparam int K_LOW = 0, K_HIGH = 1, K_SAMP = 2, K_SDA = 3;

  typedef struct { int kind; int val; string req; } item_t;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, hs_cap = 1'b1;
  logic [1:0] speed = 2'd0;
  logic [CNT_W-1:0] ss_h = 5, ss_l = 7, fs_h = 3, fs_l = 4, hs_h = 1, hs_l = 3;
  logic [SPK_W-1:0] fs_spk = 2, hs_spk = 1;
  logic [HLD_W-1:0] hold = 2;
  logic stretch_lo = 1'b0;
  logic scl_low, sample, sda_chg, enabled, scl_line;

  assign scl_line = ~scl_low & ~stretch_lo;

  scl_clock_gen #(.CNT_W(CNT_W), .SPK_W(SPK_W), .HLD_W(HLD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .speed_i(speed),
    .hs_capable_i(hs_cap), .ss_hcnt_i(ss_h), .ss_lcnt_i(ss_l),
    .fs_hcnt_i(fs_h), .fs_lcnt_i(fs_l), .hs_hcnt_i(hs_h), .hs_lcnt_i(hs_l),
    .fs_spk_i(fs_spk), .hs_spk_i(hs_spk), .sda_hold_i(hold), .scl_i(scl_line),
    .scl_low_o(scl_low), .sample_o(sample), .sda_change_o(sda_chg),
    .enabled_o(enabled)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  item_t exp_q[$];
  string scen = "";

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, scen, act, expv);
    end
  endtask

  // monitor state
  bit mon_on = 0, armed = 0, prev = 0, st_act = 0;
  int n = 0, rel = 0, t = 0;
  int st_p = -1, st_a = 0, st_g = 0, st_b = 0;

  task automatic emit(int kind, int val);
    item_t it;
    if (exp_q.size() == 0) return;
    it = exp_q.pop_front();
    chk(it.req, kind * 1000 + val, it.kind * 1000 + it.val);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!mon_on) begin
      armed = 0; prev = 0; n = 0; rel = 0; st_act = 0; stretch_lo = 1'b0;
    end else begin
      if (!armed) begin
        if (scl_low) begin armed = 1; prev = 1; n = 0; end
      end else if (scl_low != prev) begin
        emit(prev ? K_LOW : K_HIGH, n);
        if (!scl_low) begin
          if (rel == st_p) begin st_act = 1; t = 0; end
          rel++;
        end
        prev = scl_low; n = 0;
      end
      if (armed) begin
        n++;
        if (sample)  emit(K_SAMP, n - 1);
        if (sda_chg) emit(K_SDA, n - 1);
      end
      if (st_act) begin
        stretch_lo = (t < st_a) || (t >= st_a + st_g && t < st_a + st_g + st_b);
        t++;
        if (t > st_a + st_g + st_b) st_act = 0;
      end else stretch_lo = 1'b0;
    end
  end

  task automatic push(int kind, int val, string req);
    item_t it;
    it.kind = kind; it.val = val; it.req = req;
    exp_q.push_back(it);
  endtask

  // expected: per period SDA, LOW, SAMP, HIGH
  task automatic run_scen(string name, int lo, int hi_base, int spk, int hd,
                          int periods, int chg);
    int w;
    scen = name;
    exp_q.delete();
    for (int k = 0; k < periods; k++) begin
      int ex;
      ex = (k == st_p) ? (st_a + st_g + st_b) : 0;
      push(K_SDA, hd, "R9");
      push(K_LOW, lo, "R1");
      push(K_SAMP, spk + 2 + ex, "R8");
      push(K_HIGH, hi_base + ex, "R2");
    end
    @(negedge clk);
    mon_on = 1; enable = 1'b1;
    @(negedge clk);
    chk("R11", enabled, 1);
    chk("R11", scl_low, 1);
    if (chg != 0) begin
      repeat (3) @(negedge clk);
      fs_h = 9; fs_l = 9; fs_spk = 5; hold = 1; // R10: ignored while enabled
    end
    w = 0;
    while (exp_q.size() > 0 && w < 3000) begin @(negedge clk); w++; end
    chk("R1", exp_q.size(), 0);
    mon_on = 0; enable = 1'b0;
    @(negedge clk);
    chk("R11", scl_low, 0);
    chk("R11", enabled, 0);
    chk("R11", sample, 0);
    fs_h = 3; fs_l = 4; fs_spk = 2; hold = 2;
    st_p = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", scl_low, 0);
    chk("R11", enabled, 0);
    chk("R11", sample, 0);
    chk("R11", sda_chg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", scl_low, 0);

    speed = 2'd0; hold = 2;                    // R3 standard pair
    run_scen("R3_std", 8, 10, 2, 2, 3, 0);
    speed = 2'd1; hold = 0;                    // R3 fast pair, hold 0
    run_scen("R3_fast", 5, 8, 2, 0, 3, 0);
    speed = 2'd2; hold = 2;                    // R3 fast-plus uses fast pair
    run_scen("R3_fastplus", 5, 8, 2, 2, 2, 0);
    speed = 2'd3; hs_cap = 1'b1; hold = 3;     // R4 high speed with hs spike
    run_scen("R4_hs", 4, 5, 1, 3, 3, 0);
    speed = 2'd3; hs_cap = 1'b0; hold = 2;     // R5 fallback to fast
    run_scen("R5_fallback", 5, 8, 2, 2, 2, 0);
    hs_cap = 1'b1;
    speed = 2'd0; hold = 2;                    // R6 stretch, R7 glitch of SPK
    st_p = 1; st_a = 4; st_g = 2; st_b = 3;
    run_scen("R6_R7_stretch", 8, 10, 2, 2, 3, 0);
    speed = 2'd0; st_p = 0; st_a = 5; st_g = 0; st_b = 0; // R6 plain stretch
    run_scen("R6_plain", 8, 10, 2, 2, 2, 0);
    speed = 2'd1; hold = 2;                    // R10 changes while enabled
    run_scen("R10_frozen", 5, 8, 2, 2, 4, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule